// File: doc/BRIEF.md
# Composite Sync Pulse Classifier

This block watches an active-low composite sync line, sampled on the master clock that runs at four times the colour subcarrier frequency. It measures how many clock edges each low pulse lasts. When the line returns high, it sorts the pulse into one of four width classes: short (equalizing), line sync, broad (serration or blanking) and vertical. Only a pulse whose trailing edge lands inside a timing window set for each standard counts as a line sync. Every other pulse is demoted and produces no line strobe.

An accepted line sync produces a one-cycle strobe and later opens a burst-gate window of fixed delay and length. A line with no accepted pulse gets no burst window. A vertical-width pulse raises a vertical-interval flag. The first accepted line sync after it clears the flag and emits a field-start strobe. The line-standard select changes only the acceptance limits. The sync input is assumed to be synchronous to the clock.

Top module: `csync_classifier`

## Requirements
- R1: After a synchronous active-low reset, `hsync_stb`, `class_stb`, `field_stb`, `burst_gate` and `vert_flag` are 0 and `pulse_class` is 0.
- R2: The width of a pulse is the number of rising clock edges at which `csync_n` is sampled 0. `class_stb` is high for exactly one cycle, the cycle that follows the first edge at which the line is sampled 1 again.
- R3: `pulse_class` is updated together with `class_stb`. Code 0 means width < HMIN. Code 1 means HMIN ≤ width ≤ HMAX. Code 2 means HMAX < width < VMIN. Code 3 means width ≥ VMIN.
- R4: With `pal_sel`=0 the limits are HMIN=40, HMAX=76 and VMIN=200. With `pal_sel`=1 they are HMIN=57, HMAX=97 and VMIN=240.
- R5: `hsync_stb` is high for one cycle, in the cycle of `class_stb`, if and only if the code is 1.
- R6: Counting the `hsync_stb` cycle as cycle 0, `burst_gate` is high exactly in cycles BURST_DLY to BURST_DLY+BURST_LEN-1 (defaults 8 and 36).
- R7: A pulse with code 0, 2 or 3 opens no burst window, and `burst_gate` is never high before the first accepted pulse.
- R8: A code-3 pulse sets `vert_flag` in its `class_stb` cycle. Pulses with codes 0, 2 and 3 leave it set. The next code-1 pulse clears it in that pulse's `class_stb` cycle.
- R9: `field_stb` is high together with `hsync_stb` only for the first code-1 pulse after `vert_flag` was set.
- R10: The width count saturates at 2^CNT_W-1 (511 by default). A line held low for longer gives no strobe while low and is reported as code 3 on release, never wrapping into the line-sync window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 4x subcarrier |
| rst_n | input | 1 | Synchronous reset, active low |
| pal_sel | input | 1 | 0 selects the 525-line limits, 1 the 625-line limits |
| csync_n | input | 1 | Composite sync, active low, synchronous to clk |
| hsync_stb | output | 1 | One-cycle strobe for an accepted line sync |
| burst_gate | output | 1 | Burst window after an accepted line sync |
| vert_flag | output | 1 | Vertical interval in progress |
| field_stb | output | 1 | First accepted line sync after a vertical interval |
| class_stb | output | 1 | One-cycle strobe at the end of every pulse |
| pulse_class | output | 2 | Width class of the last pulse (codes per R3) |

## Verification
A wrong width count or a wrong limit shows up as a wrong `pulse_class` in the `class_stb` cycle of the very next pulse. So every width from 1 to 260 is swept in both standards, which covers each limit and its two neighbours. A stale vertical flag is visible as a missing or extra `field_stb` at the next accepted line. A timer fault shifts the edges of `burst_gate` within the same line, and these are checked cycle by cycle. A counter that wraps instead of saturating only appears after a very long low level, which is exercised once with a 600-cycle hold.

// File: rtl/csync_pkg.sv
// Shared types for the composite sync classifier.
package csync_pkg;
    // Width class codes reported on pulse_class
    typedef enum logic [1:0] {
        PC_EQ    = 2'd0,
        PC_HORIZ = 2'd1,
        PC_BROAD = 2'd2,
        PC_VERT  = 2'd3
    } pulse_class_e;
endpackage

// File: rtl/csync_width_meter.sv
// Measures the low time of csync_n in clock edges.
// Assumes csync_n is synchronous to clk. The count restarts at each falling
// level, holds while the line is high and saturates at its maximum.
module csync_width_meter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csync_n,
    output logic             trail_o,
    output logic [CNT_W-1:0] width_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             lvl_q;
    logic [CNT_W-1:0] cnt_q;

    // Remember the previous sample of the line
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= csync_n;
    end

    // Count low samples, restarting on a new pulse and saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!csync_n) begin
            if (lvl_q)               cnt_q <= CNT_W'(1);
            else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign trail_o = !lvl_q && csync_n;
    assign width_o = cnt_q;

    // R10
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!csync_n && !lvl_q && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!csync_n && !lvl_q) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/csync_sorter.sv
// Sorts each finished pulse by width into one of four classes. Drives the
// line, field and class strobes and the vertical-interval flag.
// Assumes pal_sel is stable while a pulse is being measured.
module csync_sorter
    import csync_pkg::*;
#(
    parameter int CNT_W     = 9,
    parameter int NTSC_HMIN = 40,
    parameter int NTSC_HMAX = 76,
    parameter int NTSC_VMIN = 200,
    parameter int PAL_HMIN  = 57,
    parameter int PAL_HMAX  = 97,
    parameter int PAL_VMIN  = 240
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pal_sel,
    input  logic             trail_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             class_stb,
    output pulse_class_e     pulse_class,
    output logic             hsync_stb,
    output logic             field_stb,
    output logic             vert_flag
);
    localparam logic [CNT_W-1:0] N_HMIN = CNT_W'(NTSC_HMIN);
    localparam logic [CNT_W-1:0] N_HMAX = CNT_W'(NTSC_HMAX);
    localparam logic [CNT_W-1:0] N_VMIN = CNT_W'(NTSC_VMIN);
    localparam logic [CNT_W-1:0] P_HMIN = CNT_W'(PAL_HMIN);
    localparam logic [CNT_W-1:0] P_HMAX = CNT_W'(PAL_HMAX);
    localparam logic [CNT_W-1:0] P_VMIN = CNT_W'(PAL_VMIN);

    logic [CNT_W-1:0] hmin, hmax, vmin;
    pulse_class_e     cls;

    // Pick the limits of the selected standard
    always_comb begin
        hmin = pal_sel ? P_HMIN : N_HMIN;
        hmax = pal_sel ? P_HMAX : N_HMAX;
        vmin = pal_sel ? P_VMIN : N_VMIN;
    end

    // Classify the measured width
    always_comb begin
        if (width_i < hmin)       cls = PC_EQ;
        else if (width_i <= hmax) cls = PC_HORIZ;
        else if (width_i < vmin)  cls = PC_BROAD;
        else                      cls = PC_VERT;
    end

    // Register the class and the strobes at each trailing edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            class_stb   <= 1'b0;
            pulse_class <= PC_EQ;
            hsync_stb   <= 1'b0;
            field_stb   <= 1'b0;
        end else begin
            class_stb <= trail_i;
            hsync_stb <= trail_i && (cls == PC_HORIZ);
            field_stb <= trail_i && (cls == PC_HORIZ) && vert_flag;
            if (trail_i) pulse_class <= cls;
        end
    end

    // Track the vertical interval
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vert_flag <= 1'b0;
        end else if (trail_i) begin
            if (cls == PC_VERT)       vert_flag <= 1'b1;
            else if (cls == PC_HORIZ) vert_flag <= 1'b0;
        end
    end

    // R5
    hsync_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_stb |-> ($past(width_i) >= ($past(pal_sel) ? P_HMIN : N_HMIN)) &&
                      ($past(width_i) <= ($past(pal_sel) ? P_HMAX : N_HMAX)));
    // R2
    class_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        class_stb |=> !class_stb);
    // R9
    field_with_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_stb |-> (hsync_stb && $past(vert_flag) && !vert_flag));
endmodule

// File: rtl/csync_burst_window.sv
// Opens the burst window a fixed delay after an accepted line strobe and holds
// it for a fixed length. A new strobe restarts the timer. Assumes BURST_DLY >= 1.
module csync_burst_window #(
    parameter int BURST_DLY = 8,
    parameter int BURST_LEN = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_stb,
    output logic burst_gate
);
    localparam int              LAST_I = BURST_DLY + BURST_LEN - 1;
    localparam int              TW     = $clog2(LAST_I + 2);
    localparam logic [TW-1:0]   T_DLY  = TW'(BURST_DLY);
    localparam logic [TW-1:0]   T_LAST = TW'(LAST_I);

    logic          run_q;
    logic [TW-1:0] t_q;

    // Step the window timer from each accepted line strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            t_q   <= '0;
        end else if (hsync_stb) begin
            run_q <= 1'b1;
            t_q   <= TW'(1);
        end else if (run_q) begin
            if (t_q == T_LAST) begin
                run_q <= 1'b0;
                t_q   <= '0;
            end else begin
                t_q <= t_q + TW'(1);
            end
        end
    end

    assign burst_gate = run_q && (t_q >= T_DLY) && (t_q <= T_LAST);

    // Checker state: high-run length of the gate and whether any strobe was seen
    logic [TW:0] hi_run_q;
    logic        seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q <= '0;
            seen_q   <= 1'b0;
        end else begin
            hi_run_q <= burst_gate ? hi_run_q + (TW+1)'(1) : '0;
            if (hsync_stb) seen_q <= 1'b1;
        end
    end

    // R6
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_gate |-> (hi_run_q < (TW+1)'(BURST_LEN)));
    // R7
    burst_after_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_gate |-> seen_q);
endmodule

// File: rtl/csync_classifier.sv
// Top of the composite sync classifier. Connects the width meter, the sorter
// and the burst window timer. Everything runs on the 4x subcarrier clock, and
// csync_n must be synchronous to it. VMIN limits must stay below 2**CNT_W.
module csync_classifier #(
    parameter int CNT_W     = 9,
    parameter int NTSC_HMIN = 40,
    parameter int NTSC_HMAX = 76,
    parameter int NTSC_VMIN = 200,
    parameter int PAL_HMIN  = 57,
    parameter int PAL_HMAX  = 97,
    parameter int PAL_VMIN  = 240,
    parameter int BURST_DLY = 8,
    parameter int BURST_LEN = 36
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pal_sel,
    input  logic       csync_n,
    output logic       hsync_stb,
    output logic       burst_gate,
    output logic       vert_flag,
    output logic       field_stb,
    output logic       class_stb,
    output logic [1:0] pulse_class
);
    logic                  trail;
    logic [CNT_W-1:0]      width;
    csync_pkg::pulse_class_e cls_q;

    csync_width_meter #(.CNT_W(CNT_W)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .csync_n (csync_n),
        .trail_o (trail),
        .width_o (width)
    );

    csync_sorter #(
        .CNT_W(CNT_W),
        .NTSC_HMIN(NTSC_HMIN), .NTSC_HMAX(NTSC_HMAX), .NTSC_VMIN(NTSC_VMIN),
        .PAL_HMIN(PAL_HMIN),   .PAL_HMAX(PAL_HMAX),   .PAL_VMIN(PAL_VMIN)
    ) u_sorter (
        .clk         (clk),
        .rst_n       (rst_n),
        .pal_sel     (pal_sel),
        .trail_i     (trail),
        .width_i     (width),
        .class_stb   (class_stb),
        .pulse_class (cls_q),
        .hsync_stb   (hsync_stb),
        .field_stb   (field_stb),
        .vert_flag   (vert_flag)
    );

    csync_burst_window #(.BURST_DLY(BURST_DLY), .BURST_LEN(BURST_LEN)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync_stb  (hsync_stb),
        .burst_gate (burst_gate)
    );

    assign pulse_class = cls_q;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!hsync_stb && !class_stb && !field_stb && !burst_gate && !vert_flag));
endmodule

// File: tb/tb_csync_classifier.sv
module tb_csync_classifier;
    localparam int N_HMIN = 40, N_HMAX = 76, N_VMIN = 200;
    localparam int P_HMIN = 57, P_HMAX = 97, P_VMIN = 240;
    localparam int DLY = 8, LEN = 36, GAP = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pal_sel = 1'b0;
    logic csync_n = 1'b1;
    logic hsync_stb, burst_gate, vert_flag, field_stb, class_stb;
    logic [1:0] pulse_class;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit vmodel = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    csync_classifier dut (
        .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .csync_n(csync_n),
        .hsync_stb(hsync_stb), .burst_gate(burst_gate), .vert_flag(vert_flag),
        .field_stb(field_stb), .class_stb(class_stb), .pulse_class(pulse_class)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_class(input int n, input bit pal);
        int hmin = pal ? P_HMIN : N_HMIN;
        int hmax = pal ? P_HMAX : N_HMAX;
        int vmin = pal ? P_VMIN : N_VMIN;
        if (n < hmin) return 0;
        if (n <= hmax) return 1;
        if (n < vmin) return 2;
        return 3;
    endfunction

    // Watch the line for GAP cycles after a trailing edge, expecting class c
    task automatic watch(input int c);
        bit h = (c == 1);
        bit fld = h && vmodel;
        if (c == 3) vmodel = 1'b1;
        else if (h) vmodel = 1'b0;
        for (int j = 0; j < GAP; j++) begin
            bit bexp = h && (j >= DLY) && (j <= DLY + LEN - 1);
            @(negedge clk);
            if (j == 0) begin
                chk(class_stb == 1'b1, "R2 class_stb", class_stb, 1);
                chk(int'(pulse_class) == c, "R3 R4 pulse_class", pulse_class, c);
                chk(hsync_stb == h, "R5 hsync_stb", hsync_stb, h);
                chk(field_stb == fld, "R9 field_stb", field_stb, fld);
                chk(vert_flag == vmodel, "R8 vert_flag", vert_flag, vmodel);
            end else begin
                chk(!class_stb && !hsync_stb && !field_stb, "R2 R5 strobe width",
                    {class_stb, hsync_stb, field_stb}, 0);
            end
            chk(burst_gate == bexp, h ? "R6 burst_gate" : "R7 burst_gate", burst_gate, bexp);
        end
    endtask

    task automatic run_pulse(input int n, input bit pal);
        @(negedge clk);
        pal_sel = pal;
        csync_n = 1'b0;
        repeat (n) @(negedge clk);
        csync_n = 1'b1;
        watch(exp_class(n, pal));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 180000) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 180000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!hsync_stb && !class_stb && !field_stb && !burst_gate && !vert_flag && pulse_class == 0,
            "R1 reset outputs", {hsync_stb, class_stb, field_stb, burst_gate, vert_flag, pulse_class}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!burst_gate && !class_stb, "R1 idle after reset", {burst_gate, class_stb}, 0);

        // R3 R4 R5 R6 R7 R8 R9: every width in both standards
        for (int n = 1; n <= 260; n++) run_pulse(n, 1'b0);
        for (int n = 1; n <= 260; n++) run_pulse(n, 1'b1);

        // R10: stuck-low line in the 625-line mode (a wrapped count would land in the window)
        @(negedge clk);
        pal_sel = 1'b1;
        csync_n = 1'b0;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            chk(!hsync_stb && !class_stb, "R10 no strobe while stuck low", {hsync_stb, class_stb}, 0);
        end
        csync_n = 1'b1;
        watch(3);
        // R9: next accepted line after the long pulse gives the field strobe
        run_pulse(70, 1'b1);
        run_pulse(50, 1'b0);
        finish_run();
    end
endmodule